// File: doc/BRIEF.md
# Serial Shift Port with Selectable Clock Phase

This block is an 8-bit synchronous serial shift register for a small microcontroller. Software writes a byte into the register in parallel and raises a start strobe to set BUSY. The byte then goes out most significant bit first on the serial data output. At the same time, eight bits from the serial data input are shifted in. After eight clock pulses BUSY drops by itself, shifting stops, and software reads the received byte back in parallel.

The port runs as master or as slave. As master it makes the shift clock from a programmable divide of the system clock and drives it onto the clock pin. As slave it takes the clock from the pin and passes the clock and the data input through a two-flop synchroniser, then detects edges in the system clock domain. Two controls are independent of each other. A phase control picks which clock direction samples the input and which one updates the output. An idle-level control sets the level the clock rests at between transfers. Output enables tell the surrounding pad logic whether the clock pin and the data-out pin are driven or left at high impedance.

Top module: `shift_port`

## Requirements
- R1: After reset BUSY is 0 and the shift register reads 0. In master mode the clock pin then sits at the idle level within two cycles.
- R2: A write while BUSY is 0 loads `wrData` into the register. `rdData` shows the register on the next cycle.
- R3: A write while BUSY is 1 is ignored, and the byte received by the transfer is returned unchanged.
- R4: `startWr` while BUSY is 0 sets BUSY on the next cycle. `startWr` while BUSY is 1 has no effect, so no second transfer follows.
- R5: BUSY stays 1 until the eighth pulse has returned the clock to its idle level, then clears by itself. In master mode exactly 16 clock transitions occur per transfer.
- R6: Data moves MSB first in both directions. The MSB of the loaded byte is on `sdo` before the first sampling edge.
- R7: With `altPhase` = 0 (normal phase) the input is sampled on the rising clock edge and `sdo` changes on the falling edge. This holds for both idle levels.
- R8: With `altPhase` = 1 (alternate phase) the input is sampled on the falling clock edge and `sdo` changes on the rising edge. This holds for both idle levels.
- R9: With `masterMode` = 1 the clock pin is driven (`sclkOe` = 1). Each half period lasts `clkDiv`+1 system cycles, with `clkDiv` ≥ 2. While BUSY is 0 the clock rests at `idleHigh` (1 = idle high).
- R10: With `masterMode` = 0 the clock pin is an input (`sclkOe` = 0). External clock edges while BUSY is 0 leave the register unchanged.
- R11: `sdoOe` follows `doutEn`. When it is 0 the data-out pin is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = internal clock drives pin, 0 = external clock |
| altPhase | input | 1 | 0 = sample rising/shift falling, 1 = the reverse |
| idleHigh | input | 1 | Clock idle level |
| doutEn | input | 1 | Data-out pin configured as output |
| startWr | input | 1 | Software strobe that sets BUSY |
| wrEn | input | 1 | Parallel write strobe |
| wrData | input | 8 | Parallel write data |
| clkDiv | input | 8 | Master half-period minus one, in system cycles |
| rdData | output | 8 | Parallel read of the shift register |
| busy | output | 1 | Transfer in progress |
| sclkIn | input | 1 | Clock pin input value |
| sclkOut | output | 1 | Clock pin drive value |
| sclkOe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output value |
| sdoOe | output | 1 | Serial data output enable |

## Verification
The hardest case to reach is a configuration where the eighth pulse ends on a sampling edge. In normal phase with a high idle level, or alternate phase with a low idle level, the last bit must be taken straight from the input at the same edge that ends the transfer. The bench reaches it by driving all four phase/polarity combinations both as an external master in slave mode and as an external slave in master mode. In every case it samples `sdo` just before each sampling edge. A write and a start are also injected in the middle of a slave transfer, to show that neither one disturbs the byte that arrives.

// File: rtl/shift_port_pkg.sv
package shift_port_pkg;

  // Strobes from the control to the datapath, valid for one system cycle.
  typedef struct packed {
    logic load;       // parallel write accepted
    logic sample;     // capture the synchronised input into the pending bit
    logic commit;     // shift the pending bit into the register
    logic commitNow;  // final edge is a sampling edge: shift the live input in
  } shiftStb_t;

endpackage

// File: rtl/shift_port_ctrl.sv
module shift_port_ctrl
  import shift_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  logic             altPhase,
  input  logic             idleHigh,
  input  logic             startWr,
  input  logic             wrEn,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             sclkIn,
  output shiftStb_t        stb,
  output logic             busy,
  output logic             sclkOut
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [1:0]       sclkSync;
  logic             sclkPrev;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] trailCnt;
  logic             pendValid;
  logic             busyR;
  logic             sclkR;

  logic sampleLead, divWrap, extEdge, edgeSeen, newLevel, leading;
  logic trailing, sampleEdge, shiftEdge, lastPulse, startAcc;

  // Edge classification: leading edges leave the idle level, trailing edges
  // return to it. Normal phase samples on rising, so the sampling edge is the
  // leading one exactly when phase and idle level agree.
  always_comb begin
    sampleLead = ~(altPhase ^ idleHigh);
    divWrap    = busyR && masterMode && (divCnt == clkDiv);
    extEdge    = !masterMode && busyR && (sclkSync[1] != sclkPrev);
    edgeSeen   = divWrap || extEdge;
    newLevel   = masterMode ? ~sclkR : sclkSync[1];
    leading    = (newLevel != idleHigh);
    trailing   = edgeSeen && !leading;
    sampleEdge = edgeSeen && (leading == sampleLead);
    shiftEdge  = edgeSeen && !sampleEdge;
    lastPulse  = trailing && (trailCnt == CNT_W'(DATA_W - 1));
    startAcc   = startWr && !busyR;

    stb.load      = wrEn && !busyR;
    stb.sample    = sampleEdge && !lastPulse;
    stb.commitNow = sampleEdge && lastPulse;
    stb.commit    = shiftEdge && pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync  <= '0;
      sclkPrev  <= 1'b0;
      divCnt    <= '0;
      trailCnt  <= '0;
      pendValid <= 1'b0;
      busyR     <= 1'b0;
      sclkR     <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[0], sclkIn};
      sclkPrev <= sclkSync[1];

      if (startAcc)       busyR <= 1'b1;
      else if (lastPulse) busyR <= 1'b0;

      if (startAcc)      trailCnt <= '0;
      else if (trailing) trailCnt <= trailCnt + CNT_W'(1);

      if (startAcc)        pendValid <= 1'b0;
      else if (stb.sample) pendValid <= 1'b1;
      else if (stb.commit) pendValid <= 1'b0;

      if (!busyR || !masterMode) divCnt <= '0;
      else if (divWrap)          divCnt <= '0;
      else                       divCnt <= divCnt + DIV_W'(1);

      if (!busyR)       sclkR <= idleHigh;
      else if (divWrap) sclkR <= ~sclkR;
    end
  end

  assign busy    = busyR;
  assign sclkOut = sclkR;

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyR) |-> $past(startWr));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyR |-> (trailCnt < CNT_W'(DATA_W)));

  // R9
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busyR && $stable(idleHigh)) |=>
      (busyR || !$stable(idleHigh) || sclkR == $past(idleHigh)));

endmodule

// File: rtl/shift_port_dp.sv
module shift_port_dp
  import shift_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStb_t         stb,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdi,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo
);

  logic [1:0] sdiSync;
  logic       pendBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiSync <= '0;
      pendBit <= 1'b0;
      shreg   <= '0;
    end else begin
      sdiSync <= {sdiSync[0], sdi};
      if (stb.sample) pendBit <= sdiSync[1];
      if (stb.load)
        shreg <= wrData;
      else if (stb.commit)
        shreg <= {shreg[DATA_W-2:0], pendBit};
      else if (stb.commitNow)
        shreg <= {shreg[DATA_W-2:0], sdiSync[1]};
    end
  end

  assign sdo = shreg[DATA_W-1];

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !stb.commit && !stb.commitNow) |=> $stable(shreg));

  // R7 R8
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> (!stb.commit && !stb.commitNow));

endmodule

// File: rtl/shift_port.sv
module shift_port
  import shift_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              altPhase,
  input  logic              idleHigh,
  input  logic              doutEn,
  input  logic              startWr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  clkDiv,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe
);

  shiftStb_t stb;

  shift_port_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .altPhase(altPhase),
    .idleHigh(idleHigh), .startWr(startWr), .wrEn(wrEn), .clkDiv(clkDiv),
    .sclkIn(sclkIn), .stb(stb), .busy(busy), .sclkOut(sclkOut)
  );

  shift_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busyIn(busy), .wrData(wrData),
    .sdi(sdi), .shreg(rdData), .sdo(sdo)
  );

  assign sclkOe = masterMode;
  assign sdoOe  = doutEn;

endmodule

// File: tb/sim_shift_port.sv
`timescale 1ns/1ps
module sim_shift_port;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, masterMode = 1'b0, altPhase = 1'b0, idleHigh = 1'b0;
  logic       doutEn = 1'b0, startWr = 1'b0, wrEn = 1'b0, sclkIn = 1'b0, sdi = 1'b0;
  logic [7:0] wrData = '0, clkDiv = 8'd3;
  logic [7:0] rdData;
  logic       busy, sclkOut, sclkOe, sdo, sdoOe;

  shift_port u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .altPhase(altPhase),
    .idleHigh(idleHigh), .doutEn(doutEn), .startWr(startWr), .wrEn(wrEn),
    .wrData(wrData), .clkDiv(clkDiv), .rdData(rdData), .busy(busy),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe)
  );

  int nRun = 0, nFail = 0;
  logic [15:0] expQ[$];
  logic [7:0]  txSeen = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: at each end of transfer pop the expected {rx, tx} pair.
  initial begin
    logic prevB;
    logic [15:0] e;
    prevB = 1'b0;
    forever begin
      @(negedge clk);
      if (prevB && !busy) begin
        #1;
        if (expQ.size() == 0) check(1'b0, "R5 unexpected end of transfer", 0, 1);
        else begin
          e = expQ.pop_front();
          check(rdData == e[15:8], "R6 R7 R8 received byte", rdData, e[15:8]);
          check(txSeen == e[7:0], "R6 R7 R8 sent byte", txSeen, e[7:0]);
        end
      end
      prevB = busy;
    end
  end

  // Bench as external master (DUT in slave mode).
  task automatic runSlave(input logic [7:0] tx, input logic [7:0] rx, input bit inject);
    int nSamp;
    logic lvl;
    bit smp;
    masterMode = 1'b0; sclkIn = idleHigh; sdi = rx[7];
    repeat (4) @(negedge clk);
    wrData = tx; wrEn = 1'b1; startWr = 1'b1;
    expQ.push_back({rx, tx});
    txSeen = '0; nSamp = 0;
    @(negedge clk); wrEn = 1'b0; startWr = 1'b0;
    check(busy == 1'b1, "R4 busy set by start", busy, 1);
    check(sdo == tx[7], "R6 MSB on output before first sample", sdo, tx[7]);
    for (int i = 0; i < 16; i++) begin
      repeat (8) @(negedge clk);
      lvl = ~sclkIn;
      smp = lvl ? !altPhase : altPhase;
      if (smp) txSeen = {txSeen[6:0], sdo};
      if (i == 15) check(busy == 1'b1, "R5 busy held until last edge", busy, 1);
      sclkIn = lvl;
      if (smp) nSamp++;
      else if (nSamp > 0 && nSamp < 8) sdi = rx[7-nSamp];
      if (inject && i == 6) begin
        @(negedge clk); wrData = ~tx; wrEn = 1'b1; startWr = 1'b1;
        @(negedge clk); wrEn = 1'b0; startWr = 1'b0;
      end
    end
    repeat (6) @(negedge clk);
    check(busy == 1'b0, inject ? "R4 R3 no restart after busy start" : "R5 busy cleared",
          busy, 0);
    check(sclkOe == 1'b0, "R10 clock pin is input in slave mode", sclkOe, 0);
  endtask

  // Bench as external slave (DUT in master mode).
  task automatic runMaster(input logic [7:0] tx, input logic [7:0] rx, input logic [7:0] div);
    int edges, gap, badGap, nSamp, guard;
    logic prevClk, prevSdo;
    bit smp;
    masterMode = 1'b1; clkDiv = div; sdi = rx[7];
    repeat (4) @(negedge clk);
    wrData = tx; wrEn = 1'b1; startWr = 1'b1;
    expQ.push_back({rx, tx});
    txSeen = '0;
    edges = 0; gap = 0; badGap = 0; nSamp = 0; guard = 0;
    @(negedge clk); wrEn = 1'b0; startWr = 1'b0;
    prevClk = sclkOut; prevSdo = sdo;
    while (guard < 5000) begin
      @(negedge clk);
      guard++; gap++;
      if (sclkOut != prevClk) begin
        edges++;
        if (edges > 1 && gap != int'(div) + 1) badGap++;
        gap = 0;
        smp = sclkOut ? !altPhase : altPhase;
        if (smp) begin
          txSeen = {txSeen[6:0], prevSdo};
          nSamp++;
        end else if (nSamp > 0 && nSamp < 8) sdi = rx[7-nSamp];
      end
      prevClk = sclkOut; prevSdo = sdo;
      if (!busy) break;
    end
    check(edges == 16, "R5 sixteen clock transitions", edges, 16);
    check(badGap == 0, "R9 half period equals divider plus one", badGap, 0);
    check(sclkOut == idleHigh, "R9 clock back at idle level", sclkOut, idleHigh);
    check(sclkOe == 1'b1, "R9 clock pin driven in master mode", sclkOe, 1);
  endtask

  initial begin
    #500000;
    check(1'b0, "R5 watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    masterMode = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rdData == 8'h00, "R1 register after reset", rdData, 0);
    check(sclkOut == 1'b0, "R1 master clock at idle", sclkOut, 0);

    // R2, R6, R11
    wrData = 8'hA5; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    check(rdData == 8'hA5, "R2 parallel load", rdData, 8'hA5);
    check(sdo == 1'b1, "R6 MSB on output after load", sdo, 1);
    check(sdoOe == 1'b0, "R11 data pin high impedance", sdoOe, 0);
    doutEn = 1'b1;
    @(negedge clk);
    check(sdoOe == 1'b1, "R11 data pin driven", sdoOe, 1);

    // R9 idle level follows idleHigh while not busy
    idleHigh = 1'b1;
    repeat (3) @(negedge clk);
    check(sclkOut == 1'b1, "R9 idle high", sclkOut, 1);
    idleHigh = 1'b0;
    repeat (3) @(negedge clk);
    check(sclkOut == 1'b0, "R9 idle low", sclkOut, 0);

    // Slave transfers, all phase/polarity combinations (R7, R8)
    altPhase = 1'b0; idleHigh = 1'b0; runSlave(8'hC3, 8'h5A, 1'b0);
    altPhase = 1'b0; idleHigh = 1'b1; runSlave(8'h96, 8'hE1, 1'b0);
    altPhase = 1'b1; idleHigh = 1'b0; runSlave(8'h0F, 8'hB4, 1'b0);
    altPhase = 1'b1; idleHigh = 1'b1; runSlave(8'h81, 8'h7E, 1'b0);
    // R3, R4: write and start during a transfer
    altPhase = 1'b0; idleHigh = 1'b0; runSlave(8'h6D, 8'h92, 1'b1);

    // R10: external edges while idle leave the register alone
    masterMode = 1'b0;
    wrData = 8'h3C; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    for (int i = 0; i < 10; i++) begin
      repeat (8) @(negedge clk);
      sclkIn = ~sclkIn; sdi = ~sdi;
    end
    repeat (6) @(negedge clk);
    check(rdData == 8'h3C, "R10 idle clock ignored", rdData, 8'h3C);
    check(busy == 1'b0, "R10 busy stays low", busy, 0);
    sclkIn = 1'b0;

    // Master transfers (R5, R7, R8, R9)
    altPhase = 1'b0; idleHigh = 1'b0; runMaster(8'hA7, 8'h3C, 8'd3);
    altPhase = 1'b0; idleHigh = 1'b1; runMaster(8'h1E, 8'hD9, 8'd5);
    altPhase = 1'b1; idleHigh = 1'b0; runMaster(8'hF0, 8'h0B, 8'd3);
    altPhase = 1'b1; idleHigh = 1'b1; runMaster(8'h55, 8'hAA, 8'd5);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5 all transfers completed", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule